// File: doc/BRIEF.md
# Dual Event Counter Monitoring Unit

This unit counts hardware events on two independent 40-bit counters. Each counter has a 32-bit select register. The select register picks one of 256 event inputs by an 8-bit code and sets how that event is qualified before it is counted. Each event input carries a small per-cycle count (0 to 3) and a 4-bit sub-event qualifier. A counter can add these counts directly to measure duration, add one per rising transition, or add one per cycle in which a threshold compare against a count mask holds. Counting is filtered by the current privilege mode. One enable bit, held in select register 0, starts and stops both counters together.

All four registers share one read/write port. Counter writes carry only 32 bits and are sign-extended to 40 bits from bit 31. When a counter wraps past its top value, the unit raises a single interrupt line that does not say which counter wrapped. The line stays high until software pulses a clear input. The interrupt is managed by a two-state machine: `IRQ_QUIET` (line low) and `IRQ_RAISED` (line high). The transition `T_RAISE` goes from quiet to raised when a qualifying wrap occurs. The transition `T_ACK` goes from raised to quiet when the clear is pulsed and no new wrap occurs in the same cycle.

Top module: `pmu_dual_counter`

## Requirements
- R1: A write to a counter sets bits 31:0 to the written data and fills bits 39:32 with copies of bit 31 of the data. Reading a counter returns all 40 bits.
- R2: The register address is encoded as 0 = select 0, 1 = select 1, 2 = counter 0, 3 = counter 1. Read data is registered: in the cycle after an address is presented, it shows that register's contents as they were at the clock edge. Select registers read back zero-extended to 40 bits. After reset, all registers and the read data are zero.
- R3: Select register fields are:
  - bits 7:0: event code
  - bits 15:8: unit mask
  - bit 16: user-mode enable
  - bit 17: supervisor-mode enable
  - bit 18: edge mode
  - bit 19: pin control (stored only)
  - bit 20: interrupt enable
  - bit 22: global enable
  - bit 23: invert
  - bits 31:24: count mask

  With the count mask at zero and edge mode clear, a counting counter adds the selected event's 2-bit count every cycle.
- R4: Bit 22 of select register 0 gates counting of both counters. Bit 22 of select register 1 has no effect. Writing zero to select register 0 stops both counters and leaves both counter values and select register 1 unchanged.
- R5: In edge mode, a counter adds one in each cycle where the qualified event is active and was not active in the previous cycle.
- R6: The privilege filter works as follows. With the cpl_user input high, the event counts only if bit 16 is set. With cpl_user low, it counts only if bit 17 is set. With both bits clear, nothing is counted.
- R7: If the unit mask is nonzero, the event counts only when the unit mask's low 4 bits ANDed with the event's 4-bit qualifier is nonzero. A zero unit mask disables this filter.
- R8: With a nonzero count mask, the counter adds one per cycle in which the event count is at or above the mask. With the invert bit set, it adds one per cycle in which the count is below the mask. The invert bit has no effect when the count mask is zero.
- R9: A wrap of a counter from all ones to zero raises the interrupt, provided the global enable and that counter's interrupt-enable bit are set. The interrupt stays high until irq_clr is pulsed. If a wrap and a clear occur in the same cycle, the interrupt stays high.
- R10: A counter write in the same cycle as an increment takes precedence. The written value is loaded, and any wrap in that cycle raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpl_user | input | 1 | Current mode is user (1) or supervisor (0) |
| evt_cnt | input | 512 | 2-bit per-cycle count for each of 256 events |
| evt_qual | input | 1024 | 4-bit sub-event qualifier for each of 256 events |
| reg_addr | input | 2 | Register address |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| irq_clr | input | 1 | Interrupt clear strobe |
| reg_rdata | output | 40 | Registered read data |
| irq | output | 1 | Overflow interrupt level |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a counter write and a counting increment that wraps the counter. To provoke it, the bench presets a counter to all ones while counting and writes it again on the next cycle. The result is judged by the loaded value and by a low interrupt line.

The second pair is a wrap and an interrupt clear. To provoke it, the bench holds irq_clr high across the wrap cycle and expects the line to rise anyway.

The random phase mixes both pairs freely. A cycle-exact bench model judges every cycle.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;

    localparam int EVT_CODE_W = 8;
    localparam int MASK_W     = 8;

    // Select register image; bit positions are decoded by the counting logic.
    typedef struct packed {
        logic [MASK_W-1:0]     cmask;     // 31:24
        logic                  inv;       // 23
        logic                  gen;       // 22
        logic                  rsvd;      // 21
        logic                  irq_en;    // 20
        logic                  pin;       // 19
        logic                  edge_det;  // 18
        logic                  sup_en;    // 17
        logic                  usr_en;    // 16
        logic [MASK_W-1:0]     umask;     // 15:8
        logic [EVT_CODE_W-1:0] code;      // 7:0
    } sel_t;

    typedef enum logic [1:0] {
        RA_SEL0 = 2'd0,
        RA_SEL1 = 2'd1,
        RA_CTR0 = 2'd2,
        RA_CTR1 = 2'd3
    } reg_addr_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/pmu_event_qual.sv
`timescale 1ns/1ps
module pmu_event_qual
    import pmu_pkg::*;
#(
    parameter int CNT_W  = 2,
    parameter int QUAL_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [EVT_CODE_W-1:0]         code,
    input  logic [MASK_W-1:0]             umask,
    input  logic [MASK_W-1:0]             cmask,
    input  logic                          usr_en,
    input  logic                          sup_en,
    input  logic                          edge_det,
    input  logic                          inv,
    input  logic                          cpl_user,
    input  logic [(1<<EVT_CODE_W)*CNT_W-1:0]  evt_cnt,
    input  logic [(1<<EVT_CODE_W)*QUAL_W-1:0] evt_qual,
    output logic [CNT_W-1:0]              inc
);

    localparam int PAD_W = MASK_W - CNT_W;

    logic [CNT_W-1:0]  sel_cnt;
    logic [QUAL_W-1:0] sel_qual;
    logic              umask_hit;
    logic [CNT_W-1:0]  masked_cnt;
    logic              thr_hit;
    logic [CNT_W-1:0]  level;
    logic              mode_ok;
    logic [CNT_W-1:0]  qualified;
    logic              active;
    logic              active_q;

    // Event selection by code
    assign sel_cnt  = evt_cnt[int'(code)*CNT_W +: CNT_W];
    assign sel_qual = evt_qual[int'(code)*QUAL_W +: QUAL_W];

    // Sub-event qualification
    assign umask_hit  = (umask == '0) || ((umask[QUAL_W-1:0] & sel_qual) != '0);
    assign masked_cnt = umask_hit ? sel_cnt : '0;

    // Threshold compare, optionally inverted
    always_comb begin
        if (inv) begin
            thr_hit = ({{PAD_W{1'b0}}, masked_cnt} < cmask);
        end else begin
            thr_hit = ({{PAD_W{1'b0}}, masked_cnt} >= cmask);
        end
        if (cmask == '0) begin
            level = masked_cnt;
        end else begin
            level = {{(CNT_W-1){1'b0}}, thr_hit};
        end
    end

    // Privilege filter
    assign mode_ok   = cpl_user ? usr_en : sup_en;
    assign qualified = mode_ok ? level : '0;
    assign active    = |qualified;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else begin
            active_q <= active;
        end
    end

    // Edge or level accumulation
    assign inc = edge_det ? {{(CNT_W-1){1'b0}}, (active & ~active_q)} : qualified;

    p_priv_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!usr_en && !sup_en) |-> (inc == '0))
        else $error("privilege-off event counted");

    p_edge_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_det && $stable(code) && $stable(cmask) && $stable(umask) && $stable(inv)
         && $stable(usr_en) && $stable(sup_en) && $stable(cpl_user) && $past(edge_det)
         && ($past(inc) != '0)) |-> (inc == '0))
        else $error("edge mode counted two cycles in a row");

endmodule

// File: rtl/pmu_counter.sv
`timescale 1ns/1ps
module pmu_counter #(
    parameter int CTR_W  = 40,
    parameter int DATA_W = 32,
    parameter int INC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic [INC_W-1:0]  inc,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CTR_W-1:0]  value,
    output logic              ovf
);

    localparam int EXT_W = CTR_W - DATA_W;
    localparam logic [CTR_W-1:0] STEP_MAX = CTR_W'((1 << INC_W) - 1);

    logic [CTR_W:0]   sum;
    logic [CTR_W-1:0] wr_ext;

    assign sum    = {1'b0, value} + {{(CTR_W+1-INC_W){1'b0}}, inc};
    assign wr_ext = {{EXT_W{wr_data[DATA_W-1]}}, wr_data};
    assign ovf    = count_en && !wr_en && sum[CTR_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_en) begin
            value <= wr_ext;
        end else if (count_en) begin
            value <= sum[CTR_W-1:0];
        end
    end

    p_write_sext_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (value[CTR_W-1:DATA_W] == {EXT_W{$past(wr_data[DATA_W-1])}})
                  && (value[DATA_W-1:0] == $past(wr_data)))
        else $error("counter write not sign-extended");

    p_hold_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !wr_en) |=> $stable(value))
        else $error("counter moved while stopped");

    p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !wr_en) |=> ((value - $past(value)) <= STEP_MAX))
        else $error("counter stepped too far");

endmodule

// File: rtl/pmu_irq_ctrl.sv
`timescale 1ns/1ps
module pmu_irq_ctrl
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] ovf,
    input  logic [NUM_CTR-1:0] irq_en,
    input  logic               glob_en,
    input  logic               clr,
    output logic               irq
);

    irq_state_e state, state_nx;
    logic       cause;

    assign cause = glob_en && ((ovf & irq_en) != '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= IRQ_QUIET;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: T_RAISE on a qualifying wrap, T_ACK on clear without a new wrap
    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_QUIET:  if (cause)         state_nx = IRQ_RAISED;
            IRQ_RAISED: if (clr && !cause) state_nx = IRQ_QUIET;
            default:                       state_nx = IRQ_QUIET;
        endcase
    end

    // Outputs
    always_comb begin
        irq = (state == IRQ_RAISED);
    end

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !cause) |=> !irq)
        else $error("interrupt without a wrap");

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq)
        else $error("interrupt dropped without clear");

    p_irq_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> irq)
        else $error("qualifying wrap lost");

endmodule

// File: rtl/pmu_dual_counter.sv
`timescale 1ns/1ps
module pmu_dual_counter
    import pmu_pkg::*;
#(
    parameter int CTR_W  = 40,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 2,
    parameter int QUAL_W = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cpl_user,
    input  logic [(1<<EVT_CODE_W)*CNT_W-1:0]  evt_cnt,
    input  logic [(1<<EVT_CODE_W)*QUAL_W-1:0] evt_qual,
    input  logic [1:0]                        reg_addr,
    input  logic                              reg_wen,
    input  logic [DATA_W-1:0]                 reg_wdata,
    input  logic                              irq_clr,
    output logic [CTR_W-1:0]                  reg_rdata,
    output logic                              irq
);

    localparam int NUM_CTR = 2;
    localparam int PAD_W   = CTR_W - DATA_W;

    sel_t               sel [NUM_CTR];
    logic [CTR_W-1:0]   ctr_val [NUM_CTR];
    logic [NUM_CTR-1:0] ctr_ovf;
    logic [NUM_CTR-1:0] ctr_irq_en;
    logic               glob_en;
    reg_addr_e          addr;

    assign addr    = reg_addr_e'(reg_addr);
    assign glob_en = sel[0].gen;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic [CNT_W-1:0] inc;
        logic             sel_wr;
        logic             ctr_wr;

        assign sel_wr = reg_wen && (reg_addr == 2'(i));
        assign ctr_wr = reg_wen && (reg_addr == 2'(i + 2));
        assign ctr_irq_en[i] = sel[i].irq_en;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel[i] <= '0;
            end else if (sel_wr) begin
                sel[i] <= sel_t'(reg_wdata);
            end
        end

        pmu_event_qual #(
            .CNT_W  (CNT_W),
            .QUAL_W (QUAL_W)
        ) u_qual (
            .clk      (clk),
            .rst_n    (rst_n),
            .code     (sel[i].code),
            .umask    (sel[i].umask),
            .cmask    (sel[i].cmask),
            .usr_en   (sel[i].usr_en),
            .sup_en   (sel[i].sup_en),
            .edge_det (sel[i].edge_det),
            .inv      (sel[i].inv),
            .cpl_user (cpl_user),
            .evt_cnt  (evt_cnt),
            .evt_qual (evt_qual),
            .inc      (inc)
        );

        pmu_counter #(
            .CTR_W  (CTR_W),
            .DATA_W (DATA_W),
            .INC_W  (CNT_W)
        ) u_counter (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_en (glob_en),
            .inc      (inc),
            .wr_en    (ctr_wr),
            .wr_data  (reg_wdata),
            .value    (ctr_val[i]),
            .ovf      (ctr_ovf[i])
        );
    end

    pmu_irq_ctrl #(
        .NUM_CTR (NUM_CTR)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf     (ctr_ovf),
        .irq_en  (ctr_irq_en),
        .glob_en (glob_en),
        .clr     (irq_clr),
        .irq     (irq)
    );

    // Registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else begin
            unique case (addr)
                RA_SEL0: reg_rdata <= {{PAD_W{1'b0}}, sel[0]};
                RA_SEL1: reg_rdata <= {{PAD_W{1'b0}}, sel[1]};
                RA_CTR0: reg_rdata <= ctr_val[0];
                RA_CTR1: reg_rdata <= ctr_val[1];
                default: reg_rdata <= '0;
            endcase
        end
    end

    p_sel1_gen_inert_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel[0].gen && !(reg_wen && reg_addr == 2'(RA_CTR1))) |=> $stable(ctr_val[1]))
        else $error("select 1 enable bit started counter 1");

    p_zero_sel0_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == 2'(RA_SEL0)) |=> $stable(sel[1]))
        else $error("select 0 write disturbed select 1");

endmodule

// File: tb/pmu_dual_counter_tb.sv
`timescale 1ns/1ps
module pmu_dual_counter_tb;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpl_user;
    logic [511:0]  evt_cnt_v;
    logic [1023:0] evt_q_v;
    logic [1:0]    reg_addr;
    logic          reg_wen;
    logic [31:0]   reg_wdata;
    logic          irq_clr;
    logic [39:0]   reg_rdata;
    logic          irq;

    always #2.5 clk = ~clk;

    pmu_dual_counter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpl_user  (cpl_user),
        .evt_cnt   (evt_cnt_v),
        .evt_qual  (evt_q_v),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .irq_clr   (irq_clr),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    int    nchk = 0;
    int    nerr = 0;
    string cur_req = "R2";
    logic  finished = 1'b0;

    logic [31:0] m_sel  [2];
    logic [39:0] m_ctr  [2];
    logic        m_prev [2];
    logic        m_irq;
    logic [39:0] m_rdata;

    task automatic chk(input logic [39:0] act, input logic [39:0] exp, input string what);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mksel(input logic [7:0] code, input logic [7:0] umask,
                                          input logic [7:0] cmask, input logic usr, input logic sup,
                                          input logic edg, input logic intr, input logic gen,
                                          input logic inv);
        return {cmask, inv, gen, 1'b0, intr, 1'b0, edg, sup, usr, umask, code};
    endfunction

    // Increment one counter's model would apply from the requirements
    function automatic logic [1:0] model_level(input logic [31:0] s);
        logic [1:0] c;
        logic [3:0] q;
        logic       uok;
        logic [1:0] raw;
        logic [1:0] lvl;
        logic       mode_ok;
        c   = evt_cnt_v[int'(s[7:0])*2 +: 2];
        q   = evt_q_v[int'(s[7:0])*4 +: 4];
        uok = (s[15:8] == 8'h0) || ((s[11:8] & q) != 4'h0);
        raw = uok ? c : 2'd0;
        if (s[31:24] == 8'h0) lvl = raw;
        else if (s[23])       lvl = ({6'h0, raw} <  s[31:24]) ? 2'd1 : 2'd0;
        else                  lvl = ({6'h0, raw} >= s[31:24]) ? 2'd1 : 2'd0;
        mode_ok = cpl_user ? s[16] : s[17];
        return mode_ok ? lvl : 2'd0;
    endfunction

    task automatic step();
        logic [39:0] nctr [2];
        logic [31:0] nsel [2];
        logic        nprev [2];
        logic        cause;
        logic        ge;
        logic [39:0] nrd;
        ge    = m_sel[0][22];
        cause = 1'b0;
        case (reg_addr)
            2'd0:    nrd = {8'h0, m_sel[0]};
            2'd1:    nrd = {8'h0, m_sel[1]};
            2'd2:    nrd = m_ctr[0];
            default: nrd = m_ctr[1];
        endcase
        for (int i = 0; i < 2; i++) begin
            logic [1:0]  lvl;
            logic        act;
            logic [1:0]  inc;
            logic [40:0] sum;
            logic        wr;
            lvl = model_level(m_sel[i]);
            act = (lvl != 2'd0);
            inc = m_sel[i][18] ? ((act && !m_prev[i]) ? 2'd1 : 2'd0) : lvl;
            nprev[i] = act;
            wr = reg_wen && (int'(reg_addr) == i + 2);
            nctr[i] = m_ctr[i];
            if (ge) begin
                sum = {1'b0, m_ctr[i]} + {39'h0, inc};
                nctr[i] = sum[39:0];
                if (sum[40] && m_sel[i][20] && !wr) cause = 1'b1;
            end
            if (wr) nctr[i] = {{8{reg_wdata[31]}}, reg_wdata};
            nsel[i] = (reg_wen && int'(reg_addr) == i) ? reg_wdata : m_sel[i];
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < 2; i++) begin
            m_ctr[i]  = nctr[i];
            m_sel[i]  = nsel[i];
            m_prev[i] = nprev[i];
        end
        m_irq   = cause ? 1'b1 : (irq_clr ? 1'b0 : m_irq);
        m_rdata = nrd;
        chk(reg_rdata, m_rdata, "rdata");
        chk({39'h0, irq}, {39'h0, m_irq}, "irq");
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wen   = 1'b1;
        reg_wdata = d;
        step();
        reg_wen   = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input int n);
        reg_addr = a;
        repeat (n) step();
    endtask

    task automatic set_evt(input int code, input logic [1:0] c, input logic [3:0] q);
        evt_cnt_v[code*2 +: 2] = c;
        evt_q_v[code*4 +: 4]   = q;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_2024));
        rst_n = 1'b0; cpl_user = 1'b0; evt_cnt_v = '0; evt_q_v = '0;
        reg_addr = 2'd0; reg_wen = 1'b0; reg_wdata = '0; irq_clr = 1'b0;
        for (int i = 0; i < 2; i++) begin
            m_sel[i] = '0; m_ctr[i] = '0; m_prev[i] = 1'b0;
        end
        m_irq = 1'b0; m_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state
        cur_req = "R2";
        chk(reg_rdata, 40'h0, "reset rdata");
        chk({39'h0, irq}, 40'h0, "reset irq");
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) rd(2'(a), 2);

        // R2: register readback, select zero-extension
        wr(2'd0, 32'h1234_0005);
        wr(2'd1, 32'hA5C3_5A7E);
        rd(2'd0, 2); rd(2'd1, 2);
        wr(2'd1, 32'h0); wr(2'd0, 32'h0);

        // R1: sign extension of counter writes
        cur_req = "R1";
        wr(2'd2, 32'h8000_0005); rd(2'd2, 2);
        wr(2'd3, 32'h7FFF_FFFF); rd(2'd3, 2);
        wr(2'd2, 32'h0); wr(2'd3, 32'h0);

        // R3: level counting of the whole count
        cur_req = "R3";
        wr(2'd1, mksel(8'h10, 8'h0, 8'h0, 1, 1, 0, 0, 0, 0));
        wr(2'd0, mksel(8'h2A, 8'h0, 8'h0, 1, 1, 0, 0, 1, 0));
        for (int k = 0; k < 40; k++) begin
            set_evt(8'h2A, 2'($urandom % 4), 4'h0);
            set_evt(8'h10, 2'($urandom % 4), 4'h0);
            cpl_user = 1'($urandom);
            rd(2'(2 + (k % 2)), 1);
        end

        // R4: select 1 enable bit inert, zero write to select 0 stops both
        cur_req = "R4";
        wr(2'd0, mksel(8'h2A, 8'h0, 8'h0, 1, 1, 0, 0, 0, 0));
        wr(2'd1, mksel(8'h10, 8'h0, 8'h0, 1, 1, 0, 0, 1, 1));
        set_evt(8'h10, 2'd3, 4'h0); set_evt(8'h2A, 2'd2, 4'h0);
        rd(2'd3, 8); rd(2'd2, 4);
        wr(2'd0, 32'h0);
        rd(2'd1, 3); rd(2'd2, 3); rd(2'd3, 3);

        // R5: edge mode
        cur_req = "R5";
        wr(2'd0, mksel(8'h2A, 8'h0, 8'h0, 1, 1, 1, 0, 1, 0));
        for (int k = 0; k < 50; k++) begin
            set_evt(8'h2A, ($urandom % 3 == 0) ? 2'd0 : 2'($urandom % 4), 4'h0);
            rd(2'd2, 1);
        end

        // R6: privilege filtering
        cur_req = "R6";
        wr(2'd0, mksel(8'h2A, 8'h0, 8'h0, 1, 0, 0, 0, 1, 0));
        set_evt(8'h2A, 2'd1, 4'h0);
        for (int k = 0; k < 20; k++) begin cpl_user = k[1]; rd(2'd2, 1); end
        wr(2'd0, mksel(8'h2A, 8'h0, 8'h0, 0, 1, 0, 0, 1, 0));
        for (int k = 0; k < 20; k++) begin cpl_user = k[1]; rd(2'd2, 1); end
        wr(2'd0, mksel(8'h2A, 8'h0, 8'h1, 0, 0, 0, 0, 1, 1));
        for (int k = 0; k < 20; k++) begin cpl_user = k[1]; rd(2'd2, 1); end

        // R7: unit mask against sub-event qualifier
        cur_req = "R7";
        cpl_user = 1'b1;
        wr(2'd0, mksel(8'h2A, 8'h05, 8'h0, 1, 1, 0, 0, 1, 0));
        for (int k = 0; k < 30; k++) begin set_evt(8'h2A, 2'd2, 4'(k)); rd(2'd2, 1); end
        wr(2'd0, mksel(8'h2A, 8'hF0, 8'h0, 1, 1, 0, 0, 1, 0));
        for (int k = 0; k < 16; k++) begin set_evt(8'h2A, 2'd3, 4'(k)); rd(2'd2, 1); end

        // R8: count mask threshold and invert
        cur_req = "R8";
        wr(2'd0, mksel(8'h2A, 8'h0, 8'h2, 1, 1, 0, 0, 1, 0));
        for (int k = 0; k < 24; k++) begin set_evt(8'h2A, 2'(k % 4), 4'h0); rd(2'd2, 1); end
        wr(2'd0, mksel(8'h2A, 8'h0, 8'h2, 1, 1, 0, 0, 1, 1));
        for (int k = 0; k < 24; k++) begin set_evt(8'h2A, 2'(k % 4), 4'h0); rd(2'd2, 1); end
        wr(2'd0, mksel(8'h2A, 8'h0, 8'h0, 1, 1, 0, 0, 1, 1));
        for (int k = 0; k < 12; k++) begin set_evt(8'h2A, 2'(k % 4), 4'h0); rd(2'd2, 1); end
        wr(2'd0, mksel(8'h2A, 8'h0, 8'h1, 1, 1, 1, 0, 1, 1));
        for (int k = 0; k < 24; k++) begin set_evt(8'h2A, 2'(k % 3), 4'h0); rd(2'd2, 1); end

        // R9: wrap raises interrupt, held until clear, set beats clear
        cur_req = "R9";
        wr(2'd0, 32'h0);
        wr(2'd2, 32'hFFFF_FFFE);
        set_evt(8'h2A, 2'd3, 4'h0);
        wr(2'd0, mksel(8'h2A, 8'h0, 8'h0, 1, 1, 0, 1, 1, 0));
        rd(2'd2, 6);
        irq_clr = 1'b1; step(); irq_clr = 1'b0;
        rd(2'd2, 3);
        wr(2'd1, mksel(8'h10, 8'h0, 8'h0, 1, 1, 0, 0, 0, 0));
        set_evt(8'h10, 2'd1, 4'h0);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, 4);
        wr(2'd0, mksel(8'h2A, 8'h0, 8'h0, 1, 1, 0, 1, 0, 0));
        set_evt(8'h2A, 2'd1, 4'h0);
        wr(2'd2, 32'hFFFF_FFFF);
        irq_clr = 1'b1;
        wr(2'd0, mksel(8'h2A, 8'h0, 8'h0, 1, 1, 0, 1, 1, 0));
        rd(2'd2, 2);
        irq_clr = 1'b0;
        rd(2'd2, 3);
        irq_clr = 1'b1; step(); irq_clr = 1'b0;

        // R10: write beats increment and cancels the wrap
        cur_req = "R10";
        set_evt(8'h2A, 2'd3, 4'h0);
        wr(2'd0, 32'h0);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd0, mksel(8'h2A, 8'h0, 8'h0, 1, 1, 0, 1, 1, 0));
        wr(2'd2, 32'h0000_0010);
        rd(2'd2, 4);

        // Random mix, judged by the model every cycle
        cur_req = "R3";
        for (int k = 0; k < 3000; k++) begin
            for (int w = 0; w < 16; w++) evt_cnt_v[w*32 +: 32] = $urandom;
            for (int w = 0; w < 32; w++) evt_q_v[w*32 +: 32] = $urandom;
            cpl_user = 1'($urandom);
            irq_clr  = ($urandom % 16 == 0);
            reg_addr = 2'($urandom);
            if ($urandom % 8 == 0) begin
                logic [31:0] d;
                d = $urandom;
                if (reg_addr[1] == 1'b0) begin
                    d[31:24] = ($urandom % 4 == 0) ? d[31:24] : {6'h0, d[25:24]};
                    d[7:0]   = {4'h0, d[3:0]};
                    if (reg_addr == 2'd0 && ($urandom % 4 != 0)) d[22] = 1'b1;
                end else if ($urandom % 2 == 0) begin
                    d = 32'hFFFF_FFF0 | {28'h0, d[3:0]};
                end
                reg_wen = 1'b1; reg_wdata = d;
            end
            step();
            reg_wen = 1'b0;
        end
        irq_clr = 1'b0;

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule